// File: doc/BRIEF.md
# Packed-Element Memory Fetch Sequencer

This block reads logical elements of a fixed, arbitrary bit width from a memory built of narrower physical words. The elements are stored back to back with no padding, so one element can begin partway through one word, run through whole words and end partway into another. The block takes an element index, works out the word address and bit offset at which the element begins, and then reads each word that the element touches, one word per cycle. It keeps the relevant bits of each returned word and assembles the element with its lowest bit first.

A request is offered with `req_valid` and `req_index` and is taken on a clock edge where `req_ready` is high. `req_ready` is high only while the sequencer is idle, so this is the only back-pressure: a request held during a fetch waits and has no effect until `req_ready` comes back. The response is a single-cycle `resp_valid` pulse with the element on `resp_data`. The response side has no back-pressure, so the consumer must take the data in that cycle. `req_ready` is already high in the response cycle, which allows requests to follow one another without a gap. The memory port is a plain synchronous read: the data for an address that is presented with `mem_rd_en` must be on `mem_rd_data` one cycle later.

Top module: `packed_elem_fetch`

## Requirements
- R1: After reset, `req_ready` is 1 and both `resp_valid` and `mem_rd_en` are 0. A reset during a fetch abandons that fetch and returns to this idle state.
- R2: For index i, the first read goes to word address floor(i*ELEM_W/WORD_W). It is issued in the cycle right after the edge that accepted the request.
- R3: The number of reads for an element equals ceil((ELEM_W + s)/WORD_W), where s = (i*ELEM_W) mod WORD_W. With the default widths of 8 and 19 this is 3 reads for s from 0 to 5 and 4 reads for s of 6 or 7.
- R4: From the edge that accepts a request until its response, `req_ready` stays 0 and `mem_rd_en` is never high while idle. A `req_valid` or `req_index` presented during that time does not change the response under way.
- R5: The reads of one element go to consecutive, ascending addresses, one per cycle, with no gap.
- R6: `resp_valid` rises two cycles after the last `mem_rd_en` cycle, which is exactly reads+2 cycles after the accepting edge. It stays high for one cycle only.
- R7: `resp_data` bit b equals bit (i*ELEM_W + b) of the memory viewed as a flat bit array. In that array, flat bit k is bit (k mod WORD_W) of word floor(k/WORD_W).
- R8: An element whose end falls exactly on a word boundary, so that (ELEM_W + s) mod WORD_W = 0, uses its final word in full and makes no extra partial read.
- R9: An element that starts on a word boundary (s = 0) takes its low bits from bit 0 of its first word.
- R10: `req_ready` is 1 in the cycle where `resp_valid` is 1. A request held high at that point is accepted on the next edge and is served correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The sequencer is idle and will accept a request |
| req_index | input | IDX_W | Index of the element to fetch |
| resp_valid | output | 1 | One-cycle pulse marking a finished element |
| resp_data | output | ELEM_W | Assembled element, lowest bit first |
| mem_rd_en | output | 1 | Read strobe to the memory |
| mem_addr | output | ADDR_W | Word address of the read |
| mem_rd_data | input | WORD_W | Word returned one cycle after the strobe |

## Verification
Every element index is fetched, which covers all eight start offsets in a byte. A design that gets the offset or the first-word width wrong returns shifted or corrupted bits for some indices. An element that ends exactly on a boundary is checked for an extra read, which would lengthen the response and show up in the read count and latency. A request held high while a fetch is running is checked for two faults: being taken early, which would corrupt the current element, or being lost, which would leave the following back-to-back fetch unanswered. A reset in the middle of a fetch must leave the block idle, with no read strobes still issuing.

// File: rtl/pef_pkg.sv
package pef_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FIRST,
    S_MID,
    S_LAST,
    S_WAIT
  } seq_state_t;
endpackage

// File: rtl/pef_locate.sv
// Turns an element index into its fetch plan: start word, start offset,
// bits taken from the first word, count of whole middle words, and the
// width of a trailing partial word (if any).
module pef_locate #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned ELEM_W = 19,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned OFF_W = (WORD_W > 1) ? $clog2(WORD_W) : 1,
  localparam int unsigned TK_W  = $clog2(WORD_W + 1),
  localparam int unsigned MID_W = $clog2(ELEM_W / WORD_W + 2)
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [TK_W-1:0]   first_take_o,
  output logic [MID_W-1:0]  mids_o,
  output logic              has_last_o,
  output logic [TK_W-1:0]   last_take_o
);
  int unsigned pos, ofs, endu, tot, tail;
  logic        lst;

  always_comb begin
    pos  = 32'(idx_i) * ELEM_W;
    ofs  = pos % WORD_W;
    endu = ELEM_W + ofs;
    tot  = (endu + WORD_W - 1) / WORD_W;
    tail = endu % WORD_W;
    lst  = (tot > 1) && (tail != 0);
    addr_o       = ADDR_W'(pos / WORD_W);
    off_o        = OFF_W'(ofs);
    first_take_o = TK_W'((WORD_W - ofs < ELEM_W) ? WORD_W - ofs : ELEM_W);
    mids_o       = MID_W'(tot - 1 - (lst ? 32'd1 : 32'd0));
    has_last_o   = lst;
    last_take_o  = TK_W'(tail);
  end
endmodule

// File: rtl/pef_slice.sv
// Keeps take_i bits of a word starting at bit lo_i, right-aligned.
module pef_slice #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned OFF_W = (WORD_W > 1) ? $clog2(WORD_W) : 1,
  localparam int unsigned TK_W  = $clog2(WORD_W + 1)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [OFF_W-1:0]  lo_i,
  input  logic [TK_W-1:0]   take_i,
  output logic [WORD_W-1:0] bits_o
);
  logic [WORD_W-1:0] shifted, keep;

  assign shifted = word_i >> lo_i;

  for (genvar b = 0; b < WORD_W; b++) begin : g_keep
    assign keep[b] = (TK_W'(b) < take_i);
  end

  assign bits_o = shifted & keep;
endmodule

// File: rtl/packed_elem_fetch.sv
module packed_elem_fetch
  import pef_pkg::*;
#(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned ELEM_W = 19,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_index,
  output logic              resp_valid,
  output logic [ELEM_W-1:0] resp_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rd_data
);
  localparam int unsigned OFF_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int unsigned TK_W  = $clog2(WORD_W + 1);
  localparam int unsigned MID_W = $clog2(ELEM_W / WORD_W + 2);
  localparam int unsigned COL_W = $clog2(ELEM_W + 1);

  seq_state_t        state;
  logic [ADDR_W-1:0] addr_q;
  logic [OFF_W-1:0]  off_q;
  logic [TK_W-1:0]   ftk_q, ltk_q;
  logic [MID_W-1:0]  mids_q;
  logic              has_last_q;

  logic              cap_v;
  logic [OFF_W-1:0]  cap_lo;
  logic [TK_W-1:0]   cap_take;
  logic [ELEM_W-1:0] acc, acc_next, placed;
  logic [COL_W-1:0]  col;

  logic [ADDR_W-1:0] loc_addr;
  logic [OFF_W-1:0]  loc_off;
  logic [TK_W-1:0]   loc_ftk, loc_ltk;
  logic [MID_W-1:0]  loc_mids;
  logic              loc_last;
  logic [WORD_W-1:0] slice_bits;

  pef_locate #(.WORD_W(WORD_W), .ELEM_W(ELEM_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_locate (
    .idx_i       (req_index),
    .addr_o      (loc_addr),
    .off_o       (loc_off),
    .first_take_o(loc_ftk),
    .mids_o      (loc_mids),
    .has_last_o  (loc_last),
    .last_take_o (loc_ltk)
  );

  pef_slice #(.WORD_W(WORD_W)) u_slice (
    .word_i(mem_rd_data),
    .lo_i  (cap_lo),
    .take_i(cap_take),
    .bits_o(slice_bits)
  );

  assign placed    = ELEM_W'(slice_bits) << col;
  assign acc_next  = acc | placed;
  assign req_ready = (state == S_IDLE);
  assign mem_rd_en = (state == S_FIRST) || (state == S_MID) || (state == S_LAST);
  assign mem_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      addr_q     <= '0;
      off_q      <= '0;
      ftk_q      <= '0;
      ltk_q      <= '0;
      mids_q     <= '0;
      has_last_q <= 1'b0;
      cap_v      <= 1'b0;
      cap_lo     <= '0;
      cap_take   <= '0;
      acc        <= '0;
      col        <= '0;
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= 1'b0;
      cap_v      <= mem_rd_en;
      if (cap_v) begin
        acc <= acc_next;
        col <= col + COL_W'(cap_take);
      end
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            addr_q     <= loc_addr;
            off_q      <= loc_off;
            ftk_q      <= loc_ftk;
            ltk_q      <= loc_ltk;
            mids_q     <= loc_mids;
            has_last_q <= loc_last;
            acc        <= '0;
            col        <= '0;
            state      <= S_FIRST;
          end
        end
        S_FIRST: begin
          cap_lo   <= off_q;
          cap_take <= ftk_q;
          addr_q   <= addr_q + 1'b1;
          if (mids_q != '0)    state <= S_MID;
          else if (has_last_q) state <= S_LAST;
          else                 state <= S_WAIT;
        end
        S_MID: begin
          cap_lo   <= '0;
          cap_take <= TK_W'(WORD_W);
          addr_q   <= addr_q + 1'b1;
          mids_q   <= mids_q - 1'b1;
          if (mids_q == MID_W'(1)) state <= has_last_q ? S_LAST : S_WAIT;
        end
        S_LAST: begin
          cap_lo   <= '0;
          cap_take <= ltk_q;
          addr_q   <= addr_q + 1'b1;
          state    <= S_WAIT;
        end
        S_WAIT: begin
          resp_valid <= 1'b1;
          resp_data  <= acc_next;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_no_read_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_en);
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));
  assert_resp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  assert_resp_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (!mem_rd_en && !$past(mem_rd_en)));
  assert_ready_at_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> req_ready);
endmodule

// File: tb/tb_packed_elem_fetch.sv
module tb_packed_elem_fetch;
  localparam int WORD_W = 8;
  localparam int ELEM_W = 19;
  localparam int IDX_W  = 4;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;

  // {index, first address, read count} for every element index
  localparam logic [15:0] VEC [16] = '{
    {4'd0,  8'd0,  4'd3}, {4'd1,  8'd2,  4'd3}, {4'd2,  8'd4,  4'd4}, {4'd3,  8'd7,  4'd3},
    {4'd4,  8'd9,  4'd3}, {4'd5,  8'd11, 4'd4}, {4'd6,  8'd14, 4'd3}, {4'd7,  8'd16, 4'd3},
    {4'd8,  8'd19, 4'd3}, {4'd9,  8'd21, 4'd3}, {4'd10, 8'd23, 4'd4}, {4'd11, 8'd26, 4'd3},
    {4'd12, 8'd28, 4'd3}, {4'd13, 8'd30, 4'd4}, {4'd14, 8'd33, 4'd3}, {4'd15, 8'd35, 4'd3}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [IDX_W-1:0]  req_index = '0;
  logic              resp_valid;
  logic [ELEM_W-1:0] resp_data;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [WORD_W-1:0] mem_rd_data = '0;
  logic [WORD_W-1:0] mem [DEPTH];

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  packed_elem_fetch #(.WORD_W(WORD_W), .ELEM_W(ELEM_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_index, .resp_valid, .resp_data,
    .mem_rd_en, .mem_addr, .mem_rd_data
  );

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_addr];

  function automatic int ref_elem(input int idx);
    logic [ELEM_W-1:0] r;
    for (int b = 0; b < ELEM_W; b++) begin
      int k;
      k = idx * ELEM_W + b;
      r[b] = mem[k / WORD_W][k % WORD_W];
    end
    return int'(r);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input int idx);
    @(negedge clk);
    req_index = IDX_W'(idx);
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R10 ready before request", int'(req_ready), 1);
    @(posedge clk);
  endtask

  // Called right after the accepting edge; watches until the response.
  task automatic collect(input int idx, input int exp_addr, input int exp_reads,
                         input bit hold, input int hold_idx, input string tag);
    int reads = 0, lat = 0, first = -1, data = 0;
    bit addr_ok = 1'b1, busy_ok = 1'b1, got = 1'b0;
    for (int c = 1; c <= 24 && !got; c++) begin
      @(negedge clk);
      if (c == 1) begin
        if (hold) req_index = IDX_W'(hold_idx);
        else      req_valid = 1'b0;
      end
      if (mem_rd_en) begin
        if (reads == 0) first = int'(mem_addr);
        else if (int'(mem_addr) != first + reads) addr_ok = 1'b0;
        reads++;
      end
      if (resp_valid) begin
        got  = 1'b1;
        lat  = c;
        data = int'(resp_data);
        chk(req_ready == 1'b1, {"R10 ready at response ", tag}, int'(req_ready), 1);
      end else if (req_ready) busy_ok = 1'b0;
    end
    chk(first == exp_addr, {"R2 first address ", tag}, first, exp_addr);
    chk(reads == exp_reads, {"R3 read count ", tag}, reads, exp_reads);
    chk(addr_ok, {"R5 consecutive addresses ", tag}, int'(addr_ok), 1);
    chk(lat == exp_reads + 2, {"R6 response latency ", tag}, lat, exp_reads + 2);
    chk(data == ref_elem(idx), {"R7 element data ", tag}, data, ref_elem(idx));
    chk(busy_ok, {"R4 ready low while busy ", tag}, int'(busy_ok), 1);
    if (!hold) begin
      @(negedge clk);
      chk(resp_valid == 1'b0, {"R6 single-cycle pulse ", tag}, int'(resp_valid), 0);
    end
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) mem[a] = WORD_W'((a * 73 + 29) ^ (a << 3) ^ (a >> 2));

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    chk(resp_valid == 1'b0, "R1 reset resp_valid", int'(resp_valid), 0);
    chk(mem_rd_en == 1'b0, "R1 reset mem_rd_en", int'(mem_rd_en), 0);
    rst_n = 1'b1;

    // Table walk: every index, every start offset (R7, R8 at 7/15, R9 at 0/8)
    for (int i = 0; i < 16; i++) begin
      issue(int'(VEC[i][15:12]));
      collect(int'(VEC[i][15:12]), int'(VEC[i][11:4]), int'(VEC[i][3:0]), 1'b0, 0, "table");
    end

    // R8: end exactly on a word boundary, no partial trailing read
    issue(7);
    collect(7, 16, 3, 1'b0, 0, "R8 aligned end");
    // R9: start on a word boundary
    issue(8);
    collect(8, 19, 3, 1'b0, 0, "R9 aligned start");

    // R4 + R10: request held high during a fetch, then taken back to back
    issue(5);
    collect(5, 11, 4, 1'b1, 12, "R4 held request");
    collect(12, 28, 3, 1'b0, 0, "R10 back to back");

    // R1: reset in the middle of a fetch
    issue(10);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 mid-fetch reset ready", int'(req_ready), 1);
    chk(mem_rd_en == 1'b0, "R1 mid-fetch reset mem_rd_en", int'(mem_rd_en), 0);
    chk(resp_valid == 1'b0, "R1 mid-fetch reset resp_valid", int'(resp_valid), 0);
    @(negedge clk);
    chk(mem_rd_en == 1'b0, "R1 reads stay off after reset", int'(mem_rd_en), 0);
    rst_n = 1'b1;
    issue(13);
    collect(13, 30, 4, 1'b0, 0, "R1 after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule